// File: doc/BRIEF.md
# Bounds Check Comparator Unit

This unit decides whether a register operand lies between a lower and an upper bound and produces processor-style condition flags for the result. The operand size is byte, word or long. Every operand is widened to 32 bits before the compare. The two bounds are always sign-extended from the operand size. The register value is sign-extended only when it comes from a data register. A value from an address register is always used at its full 32 bits.

The unit is registered with one cycle of latency. It accepts a new operand set on every clock edge and has no handshake. The zero flag reports a hit on either bound. The carry flag reports that the value is out of range, and that result also appears on a separate output. The extend, negative and overflow flags pass through from the incoming flag vector unchanged.

Top module: `bounds_check_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted at a rising edge, `ccr_o` and `out_of_range_o` are 0 after that edge.
- R2: Outside reset, the outputs after a rising edge reflect only the inputs sampled at that edge (one cycle of latency, one result per cycle).
- R3: `size_i` selects the operand size: 00 byte (bits 7:0), 01 word (bits 15:0), 10 long. Both bounds are sign-extended from the selected size to 32 bits, and bound bits above that size are ignored.
- R4: When `is_addr_i` is 0, the register value is sign-extended from the selected size, and its bits above that size are ignored.
- R5: When `is_addr_i` is 1, all 32 bits of the register value are used with no extension, whatever the size.
- R6: The Z flag, `ccr_o[2]`, is 1 exactly when the widened value equals the widened lower bound or the widened upper bound.
- R7: The C flag, `ccr_o[0]`, is 1 exactly when (value − lower) is greater than (upper − lower), both differences taken as unsigned 32-bit numbers.
- R8: The flag vector has the layout [4]=X, [3]=N, [2]=Z, [1]=V, [0]=C. X, N and V on `ccr_o` equal `ccr_i` bits 4, 3 and 1 from the sampled cycle.
- R9: `out_of_range_o` always equals `ccr_o[0]`.
- R10: `size_i` = 11 behaves exactly as long size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_val_i | input | 32 | Register value to test |
| is_addr_i | input | 1 | 1: the value comes from an address register and is not extended |
| size_i | input | 2 | Operand size code |
| bound_lo_i | input | 32 | Lower bound, low bits significant for smaller sizes |
| bound_hi_i | input | 32 | Upper bound, low bits significant for smaller sizes |
| ccr_i | input | 5 | Incoming X,N,Z,V,C flags |
| ccr_o | output | 5 | Updated X,N,Z,V,C flags |
| out_of_range_o | output | 1 | Value lies outside the bound pair |

## Verification
The combinational checks inside the widening and compare stages assume that the inputs are driven to known values from time zero. They also assume that the in-range property is applied only when the signed lower bound does not exceed the signed upper bound. The stimulus uses ordered bound pairs for nearly every case, and it drives defined values in every cycle, including the reset cycles. The clocked checks assume that the inputs settle away from the clock edge. The driver therefore changes them only on falling edges.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

    localparam int OP_W   = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NUM_OPS = 3;   // value, lower bound, upper bound

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_FULL2 = 2'b11
    } opsize_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic hit_bound;
        logic outside;
    } cmp_res_t;

    function automatic logic [OP_W-1:0] widen_op(
        input logic [OP_W-1:0] raw,
        input opsize_e         sz,
        input logic            do_sext
    );
        logic [OP_W-1:0] r;
        r = raw;
        if (do_sext) begin
            unique case (sz)
                SZ_BYTE: r = {{(OP_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
                SZ_HALF: r = {{(OP_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
                default: r = raw;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bchk_widen.sv
module bchk_widen
    import bchk_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W-1:0] raw_i,
    input  opsize_e      size_i,
    input  logic         sext_i,
    output logic [W-1:0] wide_o
);

    always_comb begin
        wide_o = widen_op(raw_i, size_i, sext_i);
    end

    always_comb begin
        // R5
        addr_full_chk: assert (sext_i || (wide_o == raw_i));
        // R4
        if (sext_i && size_i == SZ_BYTE)
            byte_sext_chk: assert (($signed(wide_o) >= -128) && ($signed(wide_o) <= 127));
    end

endmodule

// File: rtl/bchk_range.sv
module bchk_range
    import bchk_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output cmp_res_t     res_o
);

    logic [W-1:0] off_val;
    logic [W-1:0] span;
    logic [W:0]   chk_diff;

    always_comb begin
        off_val  = val_i - lo_i;
        span     = hi_i - lo_i;
        chk_diff = {1'b0, span} - {1'b0, off_val};
        res_o.outside   = chk_diff[W];
        res_o.hit_bound = (off_val == '0) || (chk_diff[W-1:0] == '0);
    end

    always_comb begin
        // R6
        if (val_i == lo_i || val_i == hi_i)
            z_bound_chk: assert (res_o.hit_bound);
        // R7
        if ($signed(lo_i) <= $signed(hi_i) && $signed(val_i) >= $signed(lo_i)
            && $signed(val_i) <= $signed(hi_i))
            inside_nc_chk: assert (!res_o.outside);
    end

endmodule

// File: rtl/bchk_flags.sv
module bchk_flags
    import bchk_pkg::*;
(
    input  ccr_t     ccr_i,
    input  cmp_res_t res_i,
    output ccr_t     ccr_o
);

    always_comb begin
        ccr_o   = ccr_i;
        ccr_o.z = res_i.hit_bound;
        ccr_o.c = res_i.outside;
    end

endmodule

// File: rtl/bounds_check_unit.sv
module bounds_check_unit
    import bchk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] reg_val_i,
    input  logic            is_addr_i,
    input  logic [1:0]      size_i,
    input  logic [OP_W-1:0] bound_lo_i,
    input  logic [OP_W-1:0] bound_hi_i,
    input  logic [4:0]      ccr_i,
    output logic [4:0]      ccr_o,
    output logic            out_of_range_o
);

    opsize_e         sz;
    logic [OP_W-1:0] raw_ops  [NUM_OPS];
    logic            sext_ops [NUM_OPS];
    logic [OP_W-1:0] wide_ops [NUM_OPS];
    cmp_res_t        cmp_res;
    ccr_t            ccr_in_s;
    ccr_t            ccr_nx;
    ccr_t            ccr_q;
    logic            oor_q;
    logic            primed_q;

    assign sz          = opsize_e'(size_i);
    assign raw_ops[0]  = reg_val_i;
    assign raw_ops[1]  = bound_lo_i;
    assign raw_ops[2]  = bound_hi_i;
    assign sext_ops[0] = ~is_addr_i;
    assign sext_ops[1] = 1'b1;
    assign sext_ops[2] = 1'b1;
    assign ccr_in_s    = ccr_t'(ccr_i);

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_widen
        bchk_widen #(.W(OP_W)) u_widen (
            .raw_i  (raw_ops[k]),
            .size_i (sz),
            .sext_i (sext_ops[k]),
            .wide_o (wide_ops[k])
        );
    end

    bchk_range #(.W(OP_W)) u_range (
        .val_i (wide_ops[0]),
        .lo_i  (wide_ops[1]),
        .hi_i  (wide_ops[2]),
        .res_o (cmp_res)
    );

    bchk_flags u_flags (
        .ccr_i (ccr_in_s),
        .res_i (cmp_res),
        .ccr_o (ccr_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q    <= '0;
            oor_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            ccr_q    <= ccr_nx;
            oor_q    <= cmp_res.outside;
            primed_q <= 1'b1;
        end
    end

    assign ccr_o          = ccr_q;
    assign out_of_range_o = oor_q;

    // R8
    xnv_pass_chk: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (ccr_o[4] == $past(ccr_i[4]) && ccr_o[3] == $past(ccr_i[3])
                      && ccr_o[1] == $past(ccr_i[1])));

    // R9
    oor_agree_chk: assert property (@(posedge clk) disable iff (rst)
        out_of_range_o == ccr_o[0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ccr_o == 5'd0 && !out_of_range_o));

endmodule

// File: tb/bounds_check_unit_test.sv
`timescale 1ns/1ps
module bounds_check_unit_test;

    typedef struct {
        logic [4:0] ccr;
        logic       oor;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] reg_val_i = '0;
    logic        is_addr_i = 1'b0;
    logic [1:0]  size_i = 2'b10;
    logic [31:0] bound_lo_i = '0;
    logic [31:0] bound_hi_i = '0;
    logic [4:0]  ccr_i = '0;
    logic [4:0]  ccr_o;
    logic        out_of_range_o;

    int total = 0;
    int bad = 0;
    exp_t sbq[$];

    always #4 clk = ~clk;

    bounds_check_unit uut (
        .clk(clk), .rst(rst), .reg_val_i(reg_val_i), .is_addr_i(is_addr_i),
        .size_i(size_i), .bound_lo_i(bound_lo_i), .bound_hi_i(bound_hi_i),
        .ccr_i(ccr_i), .ccr_o(ccr_o), .out_of_range_o(out_of_range_o)
    );

    function automatic logic [31:0] ext(input logic [31:0] v, input logic [1:0] sz,
                                        input logic s);
        if (!s) return v;
        if (sz == 2'b00) return {{24{v[7]}}, v[7:0]};
        if (sz == 2'b01) return {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [31:0] v, input logic a,
                         input logic [1:0] sz, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [4:0] fl);
        logic [31:0] ve, le, he;
        exp_t e;
        @(negedge clk);
        reg_val_i = v; is_addr_i = a; size_i = sz;
        bound_lo_i = lo; bound_hi_i = hi; ccr_i = fl;
        ve = ext(v, sz, !a);
        le = ext(lo, sz, 1'b1);
        he = ext(hi, sz, 1'b1);
        e.oor = ((ve - le) > (he - le));
        e.ccr = {fl[4], fl[3], (ve == le) || (ve == he), fl[1], e.oor};
        e.tag = tag;
        sbq.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, " ccr"}, {27'd0, ccr_o}, {27'd0, e.ccr});
                check({e.tag, " oor R9"}, {31'd0, out_of_range_o}, {31'd0, e.oor});
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        // R1: reset with busy inputs
        reg_val_i = 32'h1234; bound_lo_i = 32'h9999; bound_hi_i = 32'h1; ccr_i = 5'h1f;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset ccr", {27'd0, ccr_o}, 32'd0);
        check("R1 reset oor", {31'd0, out_of_range_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3 R4: byte data, negative bounds -10..5, junk upper bits
        drive("R3 R6 byte lo edge",    32'hABCD_EFF6, 1'b0, 2'b00, 32'h1111_22F6, 32'h3333_4405, 5'b00000);
        drive("R4 byte below lo",      32'h0000_00F5, 1'b0, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b10010);
        drive("R6 byte hi edge",       32'hFFFF_FF05, 1'b0, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b01000);
        drive("R7 byte above hi",      32'h0000_0006, 1'b0, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b11111);
        drive("R7 byte inside",        32'h0000_00FF, 1'b0, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b00101);
        // R5: address register, byte size, no extension
        drive("R5 addr byte eq ext lo", 32'hFFFF_FFF6, 1'b1, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b00000);
        drive("R5 addr byte unext",     32'h0000_00F6, 1'b1, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b00000);
        drive("R5 addr byte below",     32'hFFFF_FFF5, 1'b1, 2'b00, 32'h0000_00F6, 32'h0000_0005, 5'b00000);
        // word sizes, bounds -300..-2
        drive("R3 word lo edge",       32'h5555_FED4, 1'b0, 2'b01, 32'hAAAA_FED4, 32'h0000_FFFE, 5'b10000);
        drive("R4 word below lo",      32'h0000_FED3, 1'b0, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b00010);
        drive("R6 word hi edge",       32'h0000_FFFE, 1'b0, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b00000);
        drive("R7 word above hi",      32'h0000_FFFF, 1'b0, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b01000);
        drive("R5 addr word hi",       32'hFFFF_FFFE, 1'b1, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b00000);
        drive("R5 addr word unext",    32'h0000_FFFE, 1'b1, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b00000);
        drive("R5 addr word above",    32'hFFFF_FFFF, 1'b1, 2'b01, 32'h0000_FED4, 32'h0000_FFFE, 5'b00000);
        // long and size 11
        drive("R7 long inside",        32'h0001_0000, 1'b0, 2'b10, 32'h0000_8000, 32'h0100_0000, 5'b11010);
        drive("R7 long above",         32'h0100_0001, 1'b0, 2'b10, 32'h0000_8000, 32'h0100_0000, 5'b00000);
        drive("R10 size3 as long",     32'h0000_0080, 1'b0, 2'b11, 32'h0000_0010, 32'h0000_0100, 5'b00000);
        drive("R10 size3 no sext",     32'h0000_FF80, 1'b0, 2'b11, 32'h0000_FF80, 32'h0001_0000, 5'b00001);
        drive("R6 R7 lo eq hi",        32'h7FFF_FFFF, 1'b0, 2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'b00000);
        drive("R7 signed wrap below",  32'h8000_0000, 1'b0, 2'b10, 32'h8000_0001, 32'h7FFF_FFFF, 5'b00000);
        // R8 R2: flag pass-through on back-to-back cycles
        for (int k = 0; k < 32; k++)
            drive("R8 R2 flags", 32'(k - 4), k[0], 2'(k % 4), 32'hFFFF_FFFE, 32'h0000_0003, 5'(k));

        repeat (4) @(posedge clk);
        #2;
        check("R2 queue drained", sbq.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule